// File: doc/BRIEF.md
# Auto-Scan Input Channel Sequencer

This block picks the 4-bit input select code that the converter front end uses for each conversion. Software packs eight channel codes into one 32-bit word, and the block reads its select from that word.

With automatic switching off, or with any sample mode other than timer trigger, the select stays on the first code. With automatic switching on in timer-trigger mode, every conversion-done pulse moves to the next code. The scan covers a programmed number of codes and then wraps to the first one.

Alongside the live select, the block keeps the code of the channel that produced the latest result. This code is captured on the done pulse, before the select moves on.

Top module: `chan_scan_seq`

## Requirements
- R1: Slot n of `slot_word` sits at bits [4n+3:4n], and `sel_code` always equals the content of the current slot.
- R2: When `auto_en` is 0, `sel_code` equals slot 0 whatever `conv_done` does.
- R3: Scanning is active only when `auto_en` is 1 and `samp_mode` is 2'b11. Modes 2'b00, 2'b01 and 2'b10 keep `sel_code` on slot 0.
- R4: A value N on `last_idx` scans slots 0 to N and then wraps from slot N back to slot 0.
- R5: While scanning is active, a `conv_done` pulse moves `sel_code` to the next slot from the following cycle onward. Without a pulse, the slot is held.
- R6: Leaving the active scan condition returns the slot to 0, so a later scan starts at slot 0.
- R7: On each `conv_done`, `res_code` takes the `sel_code` value of that cycle. Between pulses it holds.
- R8: After reset the slot index is 0, so `sel_code` shows slot 0, and `res_code` is 0.
- R9: With `last_idx` equal to 0, scanning stays on slot 0.
- R10: If `last_idx` drops below the current slot, the next `conv_done` wraps to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_word | input | 32 | Eight packed 4-bit channel codes |
| auto_en | input | 1 | Automatic switching enable |
| samp_mode | input | 2 | Sample mode; 2'b11 is timer trigger |
| last_idx | input | 3 | Index of the last slot in the scan |
| conv_done | input | 1 | One-cycle conversion-complete pulse |
| sel_code | output | 4 | Input select for the next conversion |
| res_code | output | 4 | Channel code of the latest result |

## Verification
The properties assume that `conv_done` is a single-cycle pulse, sampled on the rising edge. They also assume that `slot_word` and `last_idx` are quasi-static: they may change, but a hold property only claims that the select is stable across cycles in which the word does not change. The directed stimulus follows these rules. It drives every input on the falling edge, pulses done for exactly one cycle, and changes configuration only between pulses.

// File: rtl/chan_scan_seq.sv
module chan_scan_seq #(
  parameter int SLOTS  = 8,
  parameter int CODE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOTS*CODE_W-1:0]   slot_word,
  input  logic                      auto_en,
  input  logic [1:0]                samp_mode,
  input  logic [$clog2(SLOTS)-1:0]  last_idx,
  input  logic                      conv_done,
  output logic [CODE_W-1:0]         sel_code,
  output logic [CODE_W-1:0]         res_code
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [CODE_W-1:0] slot [SLOTS];
  logic [IDX_W-1:0]  idx;
  logic              scan_on;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot[g] = slot_word[g*CODE_W +: CODE_W];
  end

  assign scan_on  = auto_en && (samp_mode == 2'b11);
  assign sel_code = scan_on ? slot[idx] : slot[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx <= '0;
    else if (!scan_on)
      idx <= '0;
    else if (conv_done)
      idx <= (idx >= last_idx) ? '0 : idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      res_code <= '0;
    else if (conv_done)
      res_code <= sel_code;
  end
endmodule

// File: rtl/chan_scan_seq_chk.sv
module chan_scan_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] slot_word,
  input logic        auto_en,
  input logic [1:0]  samp_mode,
  input logic [2:0]  last_idx,
  input logic        conv_done,
  input logic [3:0]  sel_code,
  input logic [3:0]  res_code
);
  logic act;
  assign act = auto_en && (samp_mode == 2'b11);

  p_fixed_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> sel_code == slot_word[3:0]);

  p_mode_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_mode != 2'b11) |-> sel_code == slot_word[3:0]);

  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> res_code == $past(sel_code));

  p_res_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(res_code));

  p_slot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !conv_done) |=> (!act || !$stable(slot_word) || $stable(sel_code)));

  p_single_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act && conv_done && last_idx == 3'd0) |=> (!act || sel_code == slot_word[3:0]));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !conv_done) |=> (!act || sel_code == slot_word[3:0]));
endmodule

bind chan_scan_seq chan_scan_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slot_word(slot_word), .auto_en(auto_en),
  .samp_mode(samp_mode), .last_idx(last_idx), .conv_done(conv_done),
  .sel_code(sel_code), .res_code(res_code)
);

// File: tb/chan_scan_seq_bench.sv
`timescale 1ns/1ps
module chan_scan_seq_bench;
  logic clk = 0, rst_n = 0;
  logic [31:0] slot_word = 32'h1FDB_9753;
  logic auto_en = 0;
  logic [1:0] samp_mode = 2'b00;
  logic [2:0] last_idx = 3'd0;
  logic conv_done = 0;
  logic [3:0] sel_code, res_code;
  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  chan_scan_seq u_chan_scan_seq (
    .clk(clk), .rst_n(rst_n), .slot_word(slot_word), .auto_en(auto_en),
    .samp_mode(samp_mode), .last_idx(last_idx), .conv_done(conv_done),
    .sel_code(sel_code), .res_code(res_code)
  );

  function automatic logic [3:0] slot_of(int n);
    return slot_word[4*n +: 4];
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse;
    @(negedge clk) conv_done = 1;
    @(negedge clk) conv_done = 0;
  endtask

  task automatic go_idle;
    @(negedge clk) auto_en = 0; samp_mode = 2'b00;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R8 sel after reset", sel_code, 4'h3);
    check("R8 res after reset", res_code, 4'h0);
  endtask

  task automatic t_auto_off;
    auto_en = 0; samp_mode = 2'b11; last_idx = 3'd7;
    for (int i = 0; i < 3; i++) begin
      pulse();
      check("R2 auto off select", sel_code, slot_of(0));
    end
    check("R7 res in auto off", res_code, slot_of(0));
  endtask

  task automatic t_mode_gate;
    auto_en = 1; last_idx = 3'd7;
    for (int m = 0; m < 3; m++) begin
      samp_mode = m[1:0];
      pulse(); pulse();
      check("R3 non-timer mode", sel_code, slot_of(0));
    end
    go_idle();
  endtask

  task automatic t_scan4;
    last_idx = 3'd3;
    @(negedge clk) auto_en = 1; samp_mode = 2'b11;
    for (int i = 1; i <= 5; i++) begin
      logic [3:0] prev;
      prev = sel_code;
      pulse();
      check("R5 R4 advance", sel_code, slot_of(i % 4));
      check("R7 captured code", res_code, prev);
    end
    @(negedge clk);
    check("R5 hold without pulse", sel_code, slot_of(1));
    go_idle();
  endtask

  task automatic t_full;
    last_idx = 3'd7;
    @(negedge clk) auto_en = 1; samp_mode = 2'b11;
    for (int i = 1; i <= 8; i++) begin
      pulse();
      check("R1 slot position", sel_code, slot_of(i % 8));
    end
    go_idle();
  endtask

  task automatic t_exit;
    last_idx = 3'd7;
    @(negedge clk) auto_en = 1; samp_mode = 2'b11;
    pulse(); pulse();
    check("R6 before exit", sel_code, slot_of(2));
    @(negedge clk) samp_mode = 2'b10;
    @(negedge clk) samp_mode = 2'b11;
    @(negedge clk);
    check("R6 restart slot 0", sel_code, slot_of(0));
    go_idle();
  endtask

  task automatic t_single;
    last_idx = 3'd0;
    @(negedge clk) auto_en = 1; samp_mode = 2'b11;
    for (int i = 0; i < 3; i++) begin
      pulse();
      check("R9 single slot", sel_code, slot_of(0));
    end
    go_idle();
  endtask

  task automatic t_shrink;
    last_idx = 3'd7;
    @(negedge clk) auto_en = 1; samp_mode = 2'b11;
    for (int i = 0; i < 5; i++) pulse();
    check("R10 at slot 5", sel_code, slot_of(5));
    @(negedge clk) last_idx = 3'd2;
    pulse();
    check("R10 wrap on shrink", sel_code, slot_of(0));
    go_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_auto_off();
    t_mode_gate();
    t_scan4();
    t_full();
    t_exit();
    t_single();
    t_shrink();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule